// File: doc/BRIEF.md
# Up/Continuous Period Timer

A 16-bit timer counter that advances on cycles where a count-enable tick is high. It has two counting modes. In up mode it counts from zero to a programmable period and then returns to zero, so one period spans period+1 ticks. In continuous mode it runs through the full 16-bit range and wraps from all-ones to zero. In that mode the period register is only a compare value. The timer can also be stopped, which holds the count.

Two sticky flags report events. The match flag is set when the count arrives at the period value. The wrap flag is set when the count returns to zero by wrapping. Each flag has its own clear strobe.

The period register can be rewritten at any time and the new value applies at once. When the new period lies below the current count, the counter rolls back to zero. At most one extra count occurs first, because the new value needs one cycle to reach the register. The same rule applies when up mode is entered while the count is already above the period.

Top module: `period_timer`

## Requirements
- R1: In up mode (mode = 2'b01), a tick while count < period makes the count count+1 after the next clock edge.
- R2: In up mode, a tick while count >= period makes the count 0 after the next clock edge.
- R3: When up mode is selected while the count is above the period, the next tick returns the count to 0 and sets the wrap flag, instead of counting upward.
- R4: In either running mode, the match flag is set at the edge where the count takes a value equal to the period register's value before that edge.
- R5: In up mode, the wrap flag is set at the edge where the count goes from the period value (or above) to 0.
- R6: An asserted period_load stores period_in, and the stored value is visible on period after the next edge. If the new period is at or above the count, counting continues up to the new value.
- R7: If the period is loaded with a value below the current count, the count rolls to 0 after at most one further increment.
- R8: In continuous mode (mode = 2'b10), the count wraps from 16'hFFFF to 0, and that transition sets the wrap flag.
- R9: In continuous mode, a count equal to the period sets the match flag but does not reset the count.
- R10: match_clr clears only the match flag, and wrap_clr clears only the wrap flag.
- R11: A set event in the same cycle as that flag's clear strobe leaves the flag set.
- R12: The count holds when tick is low, and it also holds in stop mode (mode = 2'b00 or 2'b11).
- R13: Reset (rst_n low) makes count, period and both flags 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable for this cycle |
| mode | input | 2 | 00 stop, 01 up, 10 continuous, 11 stop |
| period_in | input | 16 | New period value |
| period_load | input | 1 | Store period_in this cycle |
| match_clr | input | 1 | Clear the match flag |
| wrap_clr | input | 1 | Clear the wrap flag |
| count | output | 16 | Current count |
| period | output | 16 | Current period register |
| match_flag | output | 1 | Sticky compare-match flag |
| wrap_flag | output | 1 | Sticky wrap flag |

## Verification
The hardest case to reach is the continuous-mode wrap from all-ones. From reset it needs 65,536 ticks. The stimulus reaches it with one long continuous run, with a period of 300 in place so the same run also shows a match that does not reset the count. The rewrite below the count is timed by stepping a bench-side model until the count reaches 100 and then loading 40 with a tick in the same cycle. This brings out the one extra count before the roll to zero.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int unsigned CNT_W = 16;

    typedef enum logic [1:0] {
        MODE_STOP = 2'b00,
        MODE_UP   = 2'b01,
        MODE_CONT = 2'b10,
        MODE_HALT = 2'b11
    } ptmr_mode_e;

    localparam int unsigned FLAG_MATCH = 0;
    localparam int unsigned FLAG_WRAP  = 1;
    localparam int unsigned NUM_FLAGS  = 2;

endpackage

// File: rtl/ptmr_period_reg.sv
module ptmr_period_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] per;
    } per_state_t;

    per_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.per = din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.per;
endmodule

// File: rtl/ptmr_count_core.sv
module ptmr_count_core
    import ptmr_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [1:0]   mode,
    input  logic [W-1:0] period,
    output logic [W-1:0] count,
    output logic         match_ev,
    output logic         wrap_ev
);
    localparam logic [W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    ptmr_mode_e mode_e;
    logic       running;

    assign mode_e = ptmr_mode_e'(mode);

    always_comb begin
        st_d    = st_q;
        wrap_ev = 1'b0;
        running = 1'b0;
        if (tick) begin
            unique case (mode_e)
                MODE_UP: begin
                    running = 1'b1;
                    // at or beyond the period (incl. after a lowered period
                    // or mode entry above it) return to zero
                    if (st_q.cnt >= period) begin
                        st_d.cnt = '0;
                        wrap_ev  = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                MODE_CONT: begin
                    running  = 1'b1;
                    st_d.cnt = st_q.cnt + 1'b1;
                    wrap_ev  = (st_q.cnt == CNT_MAX);
                end
                default: begin
                    running = 1'b0;
                end
            endcase
        end
        match_ev = running && (st_d.cnt == period);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/ptmr_sticky_flags.sv
module ptmr_sticky_flags #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    logic [N-1:0] flag_d, flag_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_comb begin
            // a set event outranks a clear in the same cycle
            if (set_ev[i]) begin
                flag_d[i] = 1'b1;
            end else if (clr[i]) begin
                flag_d[i] = 1'b0;
            end else begin
                flag_d[i] = flag_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flags = flag_q;
endmodule

// File: rtl/period_timer.sv
module period_timer
    import ptmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [1:0]        mode,
    input  logic [CNT_W-1:0]  period_in,
    input  logic              period_load,
    input  logic              match_clr,
    input  logic              wrap_clr,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  period,
    output logic              match_flag,
    output logic              wrap_flag
);
    logic [CNT_W-1:0]     per_w;
    logic                 match_ev, wrap_ev;
    logic [NUM_FLAGS-1:0] set_w, clr_w, flags_w;

    ptmr_period_reg #(.W(CNT_W)) u_per (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (period_load),
        .din   (period_in),
        .dout  (per_w)
    );

    ptmr_count_core #(.W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode     (mode),
        .period   (per_w),
        .count    (count),
        .match_ev (match_ev),
        .wrap_ev  (wrap_ev)
    );

    always_comb begin
        set_w              = '0;
        clr_w              = '0;
        set_w[FLAG_MATCH]  = match_ev;
        set_w[FLAG_WRAP]   = wrap_ev;
        clr_w[FLAG_MATCH]  = match_clr;
        clr_w[FLAG_WRAP]   = wrap_clr;
    end

    ptmr_sticky_flags #(.N(NUM_FLAGS)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (set_w),
        .clr    (clr_w),
        .flags  (flags_w)
    );

    assign period     = per_w;
    assign match_flag = flags_w[FLAG_MATCH];
    assign wrap_flag  = flags_w[FLAG_WRAP];
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker
    import ptmr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [1:0]       mode,
    input logic             match_clr,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] period,
    input logic             match_flag,
    input logic             wrap_flag
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    a_r1_up_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == MODE_UP && count < period) |=> (count == $past(count) + 1'b1));

    a_r2_up_return_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == MODE_UP && count >= period) |=> (count == '0 && wrap_flag));

    a_r4_match_at_period: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_flag) |-> (count == $past(period)));

    a_r8_cont_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == MODE_CONT && count == ALL_ONES) |=> (count == '0 && wrap_flag));

    a_r10_match_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && match_clr) |=> !match_flag);

    a_r12_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));
endmodule

bind period_timer ptmr_checker u_ptmr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .mode       (mode),
    .match_clr  (match_clr),
    .count      (count),
    .period     (period),
    .match_flag (match_flag),
    .wrap_flag  (wrap_flag)
);

// File: tb/period_timer_bench.sv
module period_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [15:0] period_in = '0;
    logic        period_load = 1'b0;
    logic        match_clr = 1'b0;
    logic        wrap_clr = 1'b0;
    logic [15:0] count, period;
    logic        match_flag, wrap_flag;

    localparam logic [1:0] M_STOP = 2'b00, M_UP = 2'b01, M_CONT = 2'b10, M_HALT = 2'b11;

    always #4 clk = ~clk;

    period_timer u_period_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode),
        .period_in(period_in), .period_load(period_load),
        .match_clr(match_clr), .wrap_clr(wrap_clr),
        .count(count), .period(period),
        .match_flag(match_flag), .wrap_flag(wrap_flag)
    );

    typedef struct packed {
        logic [15:0] cnt;
        logic [15:0] per;
        logic        mf;
        logic        wf;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    errors = 0;
    int    checks = 0;
    bit    done = 0;

    // bench-side model state
    logic [15:0] m_cnt = '0, m_per = '0;
    logic        m_mf = 0, m_wf = 0;

    task automatic step(input logic t, input logic [1:0] m, input logic [15:0] pin,
                        input logic pl, input logic mc, input logic wc, input string tag);
        logic [15:0] nc;
        logic mev, wev, run;
        exp_t e;
        @(negedge clk);
        tick = t; mode = m; period_in = pin; period_load = pl;
        match_clr = mc; wrap_clr = wc;
        nc = m_cnt; wev = 0; run = 0;
        if (t && m == M_UP) begin
            run = 1;
            if (m_cnt >= m_per) begin nc = 16'd0; wev = 1; end
            else nc = m_cnt + 16'd1;
        end else if (t && m == M_CONT) begin
            run = 1;
            nc = m_cnt + 16'd1;
            wev = (m_cnt == 16'hFFFF);
        end
        mev = run && (nc == m_per);
        m_mf = mev ? 1'b1 : (mc ? 1'b0 : m_mf);
        m_wf = wev ? 1'b1 : (wc ? 1'b0 : m_wf);
        m_cnt = nc;
        if (pl) m_per = pin;
        e.cnt = m_cnt; e.per = m_per; e.mf = m_mf; e.wf = m_wf;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // monitor: compares after each edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            string tg;
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            checks++;
            if (count !== e.cnt || period !== e.per || match_flag !== e.mf || wrap_flag !== e.wf) begin
                errors++;
                $display("FAIL %s: got cnt=%0d per=%0d mf=%0b wf=%0b, expected cnt=%0d per=%0d mf=%0b wf=%0b",
                         tg, count, period, match_flag, wrap_flag, e.cnt, e.per, e.mf, e.wf);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R13: reset state
        checks++;
        if (count !== 0 || period !== 0 || match_flag !== 0 || wrap_flag !== 0) begin
            errors++;
            $display("FAIL R13: got cnt=%0d per=%0d mf=%0b wf=%0b, expected all zero",
                     count, period, match_flag, wrap_flag);
        end
        rst_n = 1'b1;

        // R6: load period 5 with a tick
        step(1, M_UP, 16'd5, 1, 0, 0, "R6");
        step(0, M_UP, 16'd0, 0, 1, 1, "R10");
        // R1 R2 R4 R5: two full up periods
        for (int i = 0; i < 12; i++) step(1, M_UP, 16'd0, 0, 0, 0, "R1 R2 R4 R5");
        // R10: clear each flag alone
        step(0, M_UP, 16'd0, 0, 1, 0, "R10");
        step(0, M_UP, 16'd0, 0, 0, 1, "R10");
        // R12: hold without tick, in stop mode and in mode 11
        for (int i = 0; i < 3; i++) step(0, M_UP, 16'd0, 0, 0, 0, "R12");
        for (int i = 0; i < 3; i++) step(1, M_STOP, 16'd0, 0, 0, 0, "R12");
        for (int i = 0; i < 3; i++) step(1, M_HALT, 16'd0, 0, 0, 0, "R12");
        // R11: match event coincides with clear
        while (m_cnt != 16'd4) step(1, M_UP, 16'd0, 0, 0, 0, "R1");
        step(1, M_UP, 16'd0, 0, 1, 1, "R11");
        step(0, M_UP, 16'd0, 0, 1, 1, "R10");
        // R6: raise period while running
        step(1, M_UP, 16'd10, 1, 0, 0, "R6");
        while (m_cnt != 16'd8) step(1, M_UP, 16'd0, 0, 0, 0, "R1");
        step(1, M_UP, 16'd20, 1, 0, 0, "R6");
        for (int i = 0; i < 14; i++) step(1, M_UP, 16'd0, 0, 0, 0, "R6");
        // R7: lower period below count
        step(1, M_UP, 16'd200, 1, 1, 1, "R6");
        while (m_cnt != 16'd100) step(1, M_UP, 16'd0, 0, 0, 0, "R1");
        step(1, M_UP, 16'd40, 1, 0, 0, "R7");
        step(1, M_UP, 16'd0, 0, 0, 0, "R7");
        step(1, M_UP, 16'd0, 0, 0, 0, "R7");
        // R3: enter up mode above the period
        step(0, M_CONT, 16'd50, 1, 1, 1, "R6");
        while (m_cnt != 16'd120) step(1, M_CONT, 16'd0, 0, 0, 0, "R9");
        step(0, M_CONT, 16'd0, 0, 1, 1, "R10");
        step(1, M_UP, 16'd0, 0, 0, 0, "R3");
        step(1, M_UP, 16'd0, 0, 0, 0, "R3");
        // R8 R9: long continuous run through the top of range
        step(0, M_CONT, 16'd300, 1, 1, 1, "R6");
        for (int i = 0; i < 65600; i++) step(1, M_CONT, 16'd0, 0, 0, 0, "R8 R9");
        step(0, M_CONT, 16'd0, 0, 0, 0, "R8");
        while (exp_q.size() > 0) @(posedge clk);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule